// File: doc/BRIEF.md
# I2C Master Bit-Level Engine

This block is the bit-level layer of an I2C master. It accepts one command at a time and turns it into SCL and SDA waveforms. The available commands are bus recovery, START, STOP, byte write and byte read, and a read carries a choice of acknowledge level. Every command is built from quarter-bit slots. The length of a slot is taken from a divider input when the command is accepted. A higher layer strings commands together into transactions, and it reads back the received byte and the acknowledge level that the engine sampled.

SCL is driven actively: `scl_out` is the driven level. SDA is open-drain: `sda_pull` high pulls the line low, and `sda_pull` low releases it. The resolved line level returns on `sda_in`. At each quarter boundary the engine sets new line levels. Those levels then hold, unchanged, until the next boundary.

States and transitions are as follows. IDLE moves to one of START, STOP, WBIT, RBIT or RCLK when a valid command arrives. START and STOP each run quarters 0..3 and then return to IDLE. WBIT runs quarters 0..3 for each bit, repeats for 8 bits, then moves to WACK. WACK runs quarters 0..4 and returns to IDLE. RBIT runs quarters 0..2 for each bit, repeats for 8 bits, then moves to RACK. RACK runs quarters 0..4 and returns to IDLE. RCLK runs quarters 0..3 for each pulse, repeats for 9 pulses, then moves to STOP. Every return to IDLE raises `done` for one cycle.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset `scl_out`=1, `sda_pull`=0, `busy`=0, `done`=0, `ack_level`=1 and `rx_byte`=0.
- R2: When a command is accepted, the engine captures `quarter_div`; a value of 0 counts as 1. Each quarter then lasts that many clock cycles. Line levels change only at quarter boundaries, and the first boundary is the accepting edge itself.
- R3: START (`cmd_op`=1) takes 4 quarters. Quarter 0 keeps the current levels, quarter 1 releases SDA, quarter 2 raises SCL and quarter 3 pulls SDA low.
- R4: STOP (`cmd_op`=2) takes 4 quarters. SCL is low in quarter 0, SDA is pulled low in quarter 1, SCL goes high in quarter 2 and SDA is released in quarter 3.
- R5: WRITE (`cmd_op`=3) sends `cmd_wdata` MSB first. Each bit takes 4 quarters: SCL low, then SDA set to the bit (a 1 releases the line), then two quarters with SCL high. SDA changes only while SCL is low.
- R6: After the 8 data bits of a WRITE there is a ninth clock. SCL goes low, SDA is released, and SCL stays high for two quarters. `sda_in` is sampled at the end of the second high quarter and stored in `ack_level` (0 means ACK). A final quarter then holds SCL low, for 37 quarters in total.
- R7: READ (`cmd_op`=4) releases SDA and takes 3 quarters per bit: SCL low, SCL high, then SCL high again. `sda_in` is sampled at the end of the first high quarter and shifted in MSB first. The byte appears on `rx_byte` by the time `done` rises.
- R8: After a READ, the engine drives the acknowledge bit: `cmd_nack`=0 pulls SDA low and `cmd_nack`=1 releases it. SCL is low, then SDA is set, then SCL is high for two quarters, then SCL is low for one quarter, for 29 quarters in total.
- R9: RECOVER (`cmd_op`=5) releases SDA and gives 9 SCL pulses, each two quarters low and two quarters high. A STOP follows, for 40 quarters in total, and the command ends with SCL high and SDA released.
- R10: A command presented while `busy` is high is ignored. Codes 0, 6 and 7 are ignored as well: they cause no `done`, no `busy` and no change on the lines.
- R11: `busy` is high from the accepting edge until the final edge. At the final edge `done` rises for exactly one cycle; this is N×div cycles after acceptance, where N is the command's quarter count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | 1 START, 2 STOP, 3 WRITE, 4 READ, 5 RECOVER |
| cmd_wdata | input | 8 | Byte to send for WRITE |
| cmd_nack | input | 1 | READ acknowledge choice: 0 ACK, 1 NACK |
| quarter_div | input | DIV_W | Clock cycles per quarter-bit slot |
| sda_in | input | 1 | Resolved SDA line level |
| scl_out | output | 1 | Driven SCL level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Last byte received |
| ack_level | output | 1 | SDA level sampled in the last WRITE acknowledge slot |

## Verification
A wrong quarter index or wrong state shows up on `scl_out` or `sda_pull` within one quarter, so the bench compares both lines to an expected pattern in every quarter of every command. A wrong bit or pulse counter produces an extra or missing clock, which shifts every later quarter and moves `done` away from its N×div cycle. A corrupt shift register shows on `sda_pull` in the next data quarter of a write. For a read it shows only on `rx_byte` when `done` rises, and the bench checks the byte there.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
    localparam logic [2:0] OP_START   = 3'd1;
    localparam logic [2:0] OP_STOP    = 3'd2;
    localparam logic [2:0] OP_WRITE   = 3'd3;
    localparam logic [2:0] OP_READ    = 3'd4;
    localparam logic [2:0] OP_RECOVER = 3'd5;

    localparam int BYTE_BITS      = 8;
    localparam int RECOVER_PULSES = 9;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_STOP, ST_WBIT, ST_WACK, ST_RBIT, ST_RACK, ST_RCLK
    } phase_e;
endpackage

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div_q - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= ONE;
            cnt_q <= '0;
        end else if (load) begin
            div_q <= (div_in == '0) ? ONE : div_in;
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + ONE;
        end
    end

    AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < div_q); // R2
endmodule

// File: rtl/i2cb_shreg.sv
module i2cb_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         bit_in,
    input  logic         capture,
    output logic         msb,
    output logic [W-1:0] rx_q
);
    logic [W-1:0] sh_q;

    assign msb = sh_q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            rx_q <= '0;
        end else begin
            if (load)          sh_q <= load_val;
            else if (shift_en) sh_q <= {sh_q[W-2:0], bit_in};
            if (capture)       rx_q <= sh_q;
        end
    end

    AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift_en)); // R5
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
    import i2cb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       cmd_nack,
    input  logic       tick,
    input  logic       tx_msb,
    input  logic       sda_in,
    output logic       take,
    output logic       busy,
    output logic       done_q,
    output logic       scl_q,
    output logic       pull_q,
    output logic       ack_q,
    output logic       shift_en,
    output logic       capture
);
    localparam int BW = $clog2(RECOVER_PULSES + 1);
    localparam logic [BW-1:0] LAST_BIT   = BW'(BYTE_BITS - 1);
    localparam logic [BW-1:0] LAST_PULSE = BW'(RECOVER_PULSES - 1);
    localparam logic [2:0] Q_BIT_END    = 3'd3;
    localparam logic [2:0] Q_ACK_SAMPLE = 3'd3;
    localparam logic [2:0] Q_ACK_END    = 3'd4;
    localparam logic [2:0] Q_RD_SAMPLE  = 3'd1;
    localparam logic [2:0] Q_RD_END     = 3'd2;

    phase_e        st_q, nxt_st;
    logic [2:0]    q_q, nxt_q;
    logic [BW-1:0] b_q, nxt_b;
    logic [2:0]    op_q;
    logic          nack_q;
    logic          advance, finish, sample_ack;

    assign busy = (st_q != ST_IDLE);

    always_comb begin
        nxt_st = st_q;
        nxt_q = q_q;
        nxt_b = b_q;
        advance = 1'b0;
        finish = 1'b0;
        take = 1'b0;
        shift_en = 1'b0;
        capture = 1'b0;
        sample_ack = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    take = 1'b1;
                    advance = 1'b1;
                    nxt_q = '0;
                    nxt_b = '0;
                    unique case (cmd_op)
                        OP_START:   nxt_st = ST_START;
                        OP_STOP:    nxt_st = ST_STOP;
                        OP_WRITE:   nxt_st = ST_WBIT;
                        OP_READ:    nxt_st = ST_RBIT;
                        OP_RECOVER: nxt_st = ST_RCLK;
                        default: begin
                            take = 1'b0;
                            advance = 1'b0;
                        end
                    endcase
                end
            end
            ST_START, ST_STOP: begin
                if (tick) begin
                    if (q_q == Q_BIT_END) finish = 1'b1;
                    else begin
                        advance = 1'b1;
                        nxt_q = q_q + 3'd1;
                    end
                end
            end
            ST_WBIT: begin
                if (tick) begin
                    advance = 1'b1;
                    if (q_q == Q_BIT_END) begin
                        shift_en = 1'b1;
                        nxt_q = '0;
                        if (b_q == LAST_BIT) nxt_st = ST_WACK;
                        else nxt_b = b_q + 1'b1;
                    end else begin
                        nxt_q = q_q + 3'd1;
                    end
                end
            end
            ST_WACK, ST_RACK: begin
                if (tick) begin
                    if (st_q == ST_WACK && q_q == Q_ACK_SAMPLE) sample_ack = 1'b1;
                    if (q_q == Q_ACK_END) finish = 1'b1;
                    else begin
                        advance = 1'b1;
                        nxt_q = q_q + 3'd1;
                    end
                end
            end
            ST_RBIT: begin
                if (tick) begin
                    advance = 1'b1;
                    if (q_q == Q_RD_SAMPLE) shift_en = 1'b1;
                    if (q_q == Q_RD_END) begin
                        nxt_q = '0;
                        if (b_q == LAST_BIT) begin
                            nxt_st = ST_RACK;
                            capture = 1'b1;
                        end else begin
                            nxt_b = b_q + 1'b1;
                        end
                    end else begin
                        nxt_q = q_q + 3'd1;
                    end
                end
            end
            ST_RCLK: begin
                if (tick) begin
                    advance = 1'b1;
                    if (q_q == Q_BIT_END) begin
                        nxt_q = '0;
                        if (b_q == LAST_PULSE) nxt_st = ST_STOP;
                        else nxt_b = b_q + 1'b1;
                    end else begin
                        nxt_q = q_q + 3'd1;
                    end
                end
            end
        endcase
        if (finish) nxt_st = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            q_q <= '0;
            b_q <= '0;
            op_q <= '0;
            nack_q <= 1'b0;
        end else begin
            st_q <= nxt_st;
            q_q <= nxt_q;
            b_q <= nxt_b;
            if (take) begin
                op_q <= cmd_op;
                nack_q <= cmd_nack;
            end
        end
    end

    // Line levels set on entry to each quarter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            pull_q <= 1'b0;
            ack_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (sample_ack) ack_q <= sda_in;
            if (advance) begin
                unique case (nxt_st)
                    ST_IDLE: ;
                    ST_START: begin
                        case (nxt_q)
                            3'd1: pull_q <= 1'b0;
                            3'd2: scl_q <= 1'b1;
                            3'd3: pull_q <= 1'b1;
                            default: ;
                        endcase
                    end
                    ST_STOP: begin
                        case (nxt_q)
                            3'd0: scl_q <= 1'b0;
                            3'd1: pull_q <= 1'b1;
                            3'd2: scl_q <= 1'b1;
                            3'd3: pull_q <= 1'b0;
                            default: ;
                        endcase
                    end
                    ST_WBIT: begin
                        case (nxt_q)
                            3'd0: scl_q <= 1'b0;
                            3'd1: pull_q <= ~tx_msb;
                            3'd2: scl_q <= 1'b1;
                            default: ;
                        endcase
                    end
                    ST_WACK: begin
                        case (nxt_q)
                            3'd0: scl_q <= 1'b0;
                            3'd1: pull_q <= 1'b0;
                            3'd2: scl_q <= 1'b1;
                            3'd4: scl_q <= 1'b0;
                            default: ;
                        endcase
                    end
                    ST_RBIT: begin
                        case (nxt_q)
                            3'd0: begin
                                scl_q <= 1'b0;
                                pull_q <= 1'b0;
                            end
                            3'd1: scl_q <= 1'b1;
                            default: ;
                        endcase
                    end
                    ST_RACK: begin
                        case (nxt_q)
                            3'd0: scl_q <= 1'b0;
                            3'd1: pull_q <= ~nack_q;
                            3'd2: scl_q <= 1'b1;
                            3'd4: scl_q <= 1'b0;
                            default: ;
                        endcase
                    end
                    ST_RCLK: begin
                        case (nxt_q)
                            3'd0: begin
                                scl_q <= 1'b0;
                                pull_q <= 1'b0;
                            end
                            3'd2: scl_q <= 1'b1;
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

    AST_LEVELS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> ($stable(scl_q) && $stable(pull_q))); // R2
    AST_WRITE_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WBIT && !$stable(pull_q)) |-> !scl_q); // R5
    AST_STOP_ENDS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && (op_q == OP_STOP || op_q == OP_RECOVER)) |-> (scl_q && !pull_q)); // R9
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_q)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R11
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $fell(busy)); // R11
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2cb_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [7:0]       cmd_wdata,
    input  logic             cmd_nack,
    input  logic [DIV_W-1:0] quarter_div,
    input  logic             sda_in,
    output logic             scl_out,
    output logic             sda_pull,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rx_byte,
    output logic             ack_level
);
    logic take, tick, tx_msb, shift_en, capture;

    i2cb_qtick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .load(take), .div_in(quarter_div),
        .run(busy), .tick(tick)
    );

    i2cb_shreg #(.W(BYTE_BITS)) u_shreg (
        .clk(clk), .rst_n(rst_n), .load(take), .load_val(cmd_wdata),
        .shift_en(shift_en), .bit_in(sda_in), .capture(capture),
        .msb(tx_msb), .rx_q(rx_byte)
    );

    i2cb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_nack(cmd_nack), .tick(tick), .tx_msb(tx_msb), .sda_in(sda_in),
        .take(take), .busy(busy), .done_q(done), .scl_q(scl_out),
        .pull_q(sda_pull), .ack_q(ack_level), .shift_en(shift_en),
        .capture(capture)
    );
endmodule

// File: tb/i2c_bit_engine_tb.sv
module i2c_bit_engine_tb;
    import i2cb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 16;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [7:0] cmd_wdata = '0;
    logic cmd_nack = 1'b0;
    logic [DIV_W-1:0] quarter_div = DIV_W'(1);
    logic slave_lvl = 1'b1;
    logic sda_in, scl_out, sda_pull, busy, done, ack_level;
    logic [7:0] rx_byte;

    assign sda_in = slave_lvl & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bit_engine #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .quarter_div(quarter_div),
        .sda_in(sda_in), .scl_out(scl_out), .sda_pull(sda_pull), .busy(busy),
        .done(done), .rx_byte(rx_byte), .ack_level(ack_level)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic exp_scl [0:39];
    logic exp_pull [0:39];
    int   exp_n;
    logic cur_scl = 1'b1;
    logic cur_pull = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic push(input logic s, input logic p);
        exp_scl[exp_n] = s;
        exp_pull[exp_n] = p;
        exp_n++;
    endtask

    // Expected per-quarter levels, derived from the requirement text
    task automatic build_expect(input logic [2:0] op, input logic [7:0] d, input logic nk);
        logic s, p;
        s = cur_scl; p = cur_pull; exp_n = 0;
        if (op == OP_START) begin
            push(s, p); p = 0; push(s, p); s = 1; push(s, p); p = 1; push(s, p);
        end else if (op == OP_WRITE) begin
            for (int i = 7; i >= 0; i--) begin
                s = 0; push(s, p); p = ~d[i]; push(s, p); s = 1; push(s, p); push(s, p);
            end
            s = 0; push(s, p); p = 0; push(s, p); s = 1; push(s, p); push(s, p); s = 0; push(s, p);
        end else if (op == OP_READ) begin
            for (int i = 0; i < 8; i++) begin
                s = 0; p = 0; push(s, p); s = 1; push(s, p); push(s, p);
            end
            s = 0; push(s, p); p = ~nk; push(s, p); s = 1; push(s, p); push(s, p); s = 0; push(s, p);
        end else if (op == OP_RECOVER) begin
            for (int i = 0; i < 9; i++) begin
                s = 0; p = 0; push(s, p); push(s, p); s = 1; push(s, p); push(s, p);
            end
        end
        if (op == OP_STOP || op == OP_RECOVER) begin
            s = 0; push(s, p); p = 1; push(s, p); s = 1; push(s, p); p = 0; push(s, p);
        end
        cur_scl = s; cur_pull = p;
    endtask

    function automatic string tag_for(input logic [2:0] op, input int n);
        if (op == OP_START) return "R3";
        if (op == OP_STOP) return "R4";
        if (op == OP_WRITE) return (n < 32) ? "R5" : "R6";
        if (op == OP_READ) return (n < 24) ? "R7" : "R8";
        return "R9";
    endfunction

    task automatic run_cmd(input logic [2:0] op, input logic [7:0] d, input logic nk,
                           input int div, input logic ack_resp, input logic [7:0] rbyte,
                           input bit inject);
        int deff;
        deff = (div == 0) ? 1 : div;
        build_expect(op, d, nk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d; cmd_nack = nk;
        quarter_div = DIV_W'(div);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int n = 0; n < exp_n; n++) begin
            if (op == OP_READ) begin
                if (n < 24 && (n % 3) == 0) slave_lvl = rbyte[7 - n/3];
                else if (n == 24) slave_lvl = 1'b1;
            end
            if (op == OP_WRITE && n == 32) slave_lvl = ack_resp;
            chk(scl_out === exp_scl[n] && sda_pull === exp_pull[n], tag_for(op, n),
                {scl_out, sda_pull}, {exp_scl[n], exp_pull[n]});
            chk(busy === 1'b1 && done === 1'b0, "R11", {busy, done}, 2'b10);
            if (inject && n == 1) begin
                cmd_valid = 1'b1; cmd_op = OP_STOP;   // R10: must be ignored while busy
                @(negedge clk);
                cmd_valid = 1'b0;
                repeat (deff - 1) @(negedge clk);
            end else begin
                repeat (deff) @(negedge clk);
            end
        end
        chk(done === 1'b1 && busy === 1'b0, "R11", {busy, done}, 2'b01);
        if (op == OP_WRITE) chk(ack_level === ack_resp, "R6", ack_level, ack_resp);
        if (op == OP_READ)  chk(rx_byte === rbyte, "R7", rx_byte, rbyte);
        @(negedge clk);
        chk(done === 1'b0, "R11", done, 0);
        slave_lvl = 1'b1;
    endtask

    task automatic bad_op(input logic [2:0] op);
        bit seen;
        seen = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (done || busy) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen && scl_out === cur_scl && sda_pull === cur_pull, "R10",
            {seen, scl_out, sda_pull}, {1'b0, cur_scl, cur_pull});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
                report();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(scl_out === 1'b1 && sda_pull === 1'b0, "R1", {scl_out, sda_pull}, 2'b10);
        chk(busy === 1'b0 && done === 1'b0, "R1", {busy, done}, 0);
        chk(ack_level === 1'b1 && rx_byte === 8'h00, "R1", {ack_level, rx_byte}, 9'h100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_cmd(OP_RECOVER, 8'h00, 1'b0, 2, 1'b1, 8'h00, 1'b0);  // R9
        run_cmd(OP_START,   8'h00, 1'b0, 1, 1'b1, 8'h00, 1'b0);  // R3
        run_cmd(OP_WRITE,   8'hA5, 1'b0, 3, 1'b0, 8'h00, 1'b0);  // R5 R6 ack
        run_cmd(OP_WRITE,   8'h3C, 1'b0, 0, 1'b1, 8'h00, 1'b0);  // R2 div 0, R6 nack
        run_cmd(OP_START,   8'h00, 1'b0, 2, 1'b1, 8'h00, 1'b0);  // repeated start
        run_cmd(OP_READ,    8'h00, 1'b0, 2, 1'b1, 8'h96, 1'b0);  // R7 R8 ack
        run_cmd(OP_READ,    8'h00, 1'b1, 1, 1'b1, 8'h01, 1'b0);  // R8 nack
        run_cmd(OP_STOP,    8'h00, 1'b0, 4, 1'b1, 8'h00, 1'b0);  // R4
        run_cmd(OP_WRITE,   8'hFF, 1'b0, 2, 1'b0, 8'h00, 1'b1);  // R10 busy inject
        bad_op(3'd0);                                            // R10
        bad_op(3'd6);
        bad_op(3'd7);

        for (int k = 0; k < 50; k++) begin
            logic [2:0] op;
            op = 3'(1 + ($urandom % 5));
            run_cmd(op, 8'($urandom), 1'($urandom), int'($urandom % 5),
                    1'($urandom), 8'($urandom), (k % 7) == 3);
        end
        report();
    end
endmodule